// File: doc/BRIEF.md
# Flash Operation Command Sequencer

This block sits between a register front end and a simple flash array port. Software first loads a byte address. It then writes a control word that names the operation, the partition, the info-page type, the erase kind and a word count. The sequencer runs one operation at a time. A read moves words from the array into an internal read FIFO. A program moves words from an internal program FIFO into the array. An erase issues a single page or bank erase request. When the operation ends, a done flag and an error flag are raised. A set of cause bits records why an operation failed.

Every transfer with the array is a request/acknowledge handshake. Back pressure works in both directions. A read waits while the read FIFO has no free slot. A program waits while the program FIFO holds no word. A program that would run past the end of its aligned program window is refused before it touches the array. After reset the block spends a fixed number of cycles in an initialisation phase, and it refuses work during that phase.

Top module: `flash_op_seq`

## Requirements
- R1: The control word is decoded as follows. Bit 0 is start. Bits [2:1] are the operation: 0 read, 1 program, 2 erase, 3 invalid. Bit 3 selects the info partition. Bits [5:4] are the info type. Bit 6 selects a bank erase (0 means page erase). Bits [27:16] are the count. While an operation runs, `fl_op`, `fl_part`, `fl_info` and `fl_bank` carry these decoded values.
- R2: The count field holds the number of 32-bit words minus one. A read or a program performs exactly count+1 array handshakes.
- R3: For a read or a program, the first array address is the loaded address with bits [1:0] cleared. Each later word is 4 bytes higher.
- R4: An erase performs one handshake. A page erase clears the address bits below the 2 KiB page size. A bank erase clears the bits below the bank size of 16 pages (32 KiB).
- R5: A program whose word offset inside its 64-byte window, plus the count field, reaches 16 or more is refused. It sets done and error in the cycle after the start and sets cause bit 3, with no array request. A read is never refused for crossing a window.
- R6: No read request is made while the 4-entry read FIFO is full. Read words leave `rdf_rdata` in array order.
- R7: A program makes no request while the program FIFO is empty. It sends the words to `fl_wdata` in the order they were pushed.
- R8: Done rises in the cycle after the last handshake. Error rises together with done if the array flagged an error during the operation. The cause bits are: bit 1 for a read, bit 2 for a program, bit 4 for an erase. A pulse on `opstat_clr` clears done and error. The cause bits hold until the next accepted start clears them.
- R9: A start while an operation is in progress, or while `init_wip` is high, is ignored. It produces no array request and does not change the running operation.
- R10: An invalid operation code sets done, error and cause bit 0 in the cycle after the start, and makes no array request.
- R11: `init_wip` is high for 8 cycles after reset is released. The FIFO full and empty flags match the FIFO occupancy (depth 4).
- R12: While in reset, done, error, busy and `fl_req` are low, and both FIFOs report empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Load the address register |
| addr_wdata | input | 20 | Byte address to load |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| opstat_clr | input | 1 | Clear done and error |
| op_done | output | 1 | Operation finished |
| op_err | output | 1 | Operation finished with an error |
| err_cause | output | 5 | Cause bits {erase, window, program, read, op code} |
| busy | output | 1 | Operation in progress |
| rdf_full | output | 1 | Read FIFO full |
| rdf_empty | output | 1 | Read FIFO empty |
| pgf_full | output | 1 | Program FIFO full |
| pgf_empty | output | 1 | Program FIFO empty |
| init_wip | output | 1 | Initialisation in progress |
| rdf_pop | input | 1 | Pop one word from the read FIFO |
| rdf_rdata | output | 32 | Head of the read FIFO |
| pgf_push | input | 1 | Push one word into the program FIFO |
| pgf_wdata | input | 32 | Word to push |
| fl_req | output | 1 | Array request |
| fl_op | output | 2 | Array operation |
| fl_part | output | 1 | Info partition select |
| fl_info | output | 2 | Info type |
| fl_bank | output | 1 | Bank erase select |
| fl_addr | output | 20 | Array byte address |
| fl_wdata | output | 32 | Program data |
| fl_ack | input | 1 | Array acknowledge |
| fl_rdata | input | 32 | Array read data |
| fl_err | input | 1 | Array error, valid with acknowledge |

## Verification
An accepted start is registered at one clock edge. A refused program or an invalid code therefore shows done, error and cause at the negative edge that follows that edge. The first array request appears in the same cycle. Each handshake is registered at the next edge. The bench's reference queues advance at every negative edge, so FIFO flags, read data and program data are compared one cycle after the handshake that caused them. Done is due one edge after the last handshake. The bench waits for it with a bounded loop and then checks error and cause at that same negative edge.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_ERASE = 2'd2
    } st_e;

    typedef struct packed {
        logic macro;
        logic win;
        logic prog;
        logic rd;
        logic op;
    } cause_t;

    localparam int unsigned CTL_START   = 0;
    localparam int unsigned CTL_OP_LSB  = 1;
    localparam int unsigned CTL_PART    = 3;
    localparam int unsigned CTL_INFO_LSB = 4;
    localparam int unsigned CTL_BANK    = 6;
    localparam int unsigned CTL_CNT_LSB = 16;

endpackage

// File: rtl/flash_seq_fifo.sv
module flash_seq_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t         p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    assign full    = (p_q.cnt == CW'(DEPTH));
    assign empty   = (p_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[p_q.rp];

    always_comb begin
        p_d = p_q;
        if (do_push) begin
            p_d.wp = (p_q.wp == PW'(DEPTH - 1)) ? '0 : p_q.wp + 1'b1;
        end
        if (do_pop) begin
            p_d.rp = (p_q.rp == PW'(DEPTH - 1)) ? '0 : p_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wp] <= wdata;
    end

endmodule

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
    import flash_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned WIN_BYTES  = 64,
    parameter int unsigned PAGE_BYTES = 2048,
    parameter int unsigned BANK_PAGES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  op_e               op,
    input  logic              bank,
    input  logic [CNT_W-1:0]  cnt_m1,
    output logic [ADDR_W-1:0] start_addr,
    output logic              win_cross
);
    localparam int unsigned WIN_LSB    = $clog2(WIN_BYTES);
    localparam int unsigned WIN_WORDS  = WIN_BYTES / 4;
    localparam int unsigned BANK_BYTES = PAGE_BYTES * BANK_PAGES;
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);
    localparam logic [ADDR_W-1:0] BANK_MASK = ~ADDR_W'(BANK_BYTES - 1);

    logic [WIN_LSB-3:0] word_off;
    logic [CNT_W:0]     span;

    assign word_off = addr[WIN_LSB-1:2];
    assign span     = (CNT_W+1)'(word_off) + (CNT_W+1)'(cnt_m1);

    always_comb begin
        if (op == OP_ERASE) begin
            start_addr = addr & (bank ? BANK_MASK : PAGE_MASK);
        end else begin
            start_addr = addr & WORD_MASK;
        end
        win_cross = (op == OP_PROG) && (span >= (CNT_W+1)'(WIN_WORDS));
    end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned FIFO_DEPTH  = 4,
    parameter int unsigned WIN_BYTES   = 64,
    parameter int unsigned PAGE_BYTES  = 2048,
    parameter int unsigned BANK_PAGES  = 16,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              opstat_clr,
    output logic              op_done,
    output logic              op_err,
    output logic [4:0]        err_cause,
    output logic              busy,
    output logic              rdf_full,
    output logic              rdf_empty,
    output logic              pgf_full,
    output logic              pgf_empty,
    output logic              init_wip,
    input  logic              rdf_pop,
    output logic [31:0]       rdf_rdata,
    input  logic              pgf_push,
    input  logic [31:0]       pgf_wdata,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic              fl_part,
    output logic [1:0]        fl_info,
    output logic              fl_bank,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [31:0]       fl_wdata,
    input  logic              fl_ack,
    input  logic [31:0]       fl_rdata,
    input  logic              fl_err
);
    localparam int unsigned INIT_W = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr_reg;
        logic [ADDR_W-1:0] cur;
        logic [CNT_W-1:0]  left;
        op_e               op;
        logic              part;
        logic [1:0]        info;
        logic              bank;
        logic              done;
        logic              err;
        cause_t            cause;
        logic [INIT_W-1:0] init_cnt;
    } seq_t;

    seq_t              s_d, s_q;
    op_e               op_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_cross;
    logic              fire;
    logic              rd_push, pg_pop;
    logic              unused_ctrl;

    assign op_w  = op_e'(ctrl_wdata[CTL_OP_LSB +: 2]);
    assign cnt_w = ctrl_wdata[CTL_CNT_LSB +: CNT_W];
    assign unused_ctrl = ^{ctrl_wdata[31:CTL_CNT_LSB+CNT_W], ctrl_wdata[CTL_CNT_LSB-1:CTL_BANK+1]};

    flash_seq_decode #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .WIN_BYTES (WIN_BYTES),
        .PAGE_BYTES(PAGE_BYTES),
        .BANK_PAGES(BANK_PAGES)
    ) u_decode (
        .addr      (s_q.addr_reg),
        .op        (op_w),
        .bank      (ctrl_wdata[CTL_BANK]),
        .cnt_m1    (cnt_w),
        .start_addr(dec_addr),
        .win_cross (dec_cross)
    );

    // Array request: a transfer waits on FIFO room or data, an erase goes at once.
    always_comb begin
        fl_req = 1'b0;
        if (s_q.st == ST_XFER) begin
            fl_req = (s_q.op == OP_READ) ? !rdf_full : !pgf_empty;
        end else if (s_q.st == ST_ERASE) begin
            fl_req = 1'b1;
        end
    end

    assign fire    = fl_req && fl_ack;
    assign rd_push = fire && (s_q.st == ST_XFER) && (s_q.op == OP_READ);
    assign pg_pop  = fire && (s_q.st == ST_XFER) && (s_q.op == OP_PROG);

    flash_seq_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rd_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rd_push),
        .wdata(fl_rdata),
        .pop  (rdf_pop),
        .rdata(rdf_rdata),
        .full (rdf_full),
        .empty(rdf_empty)
    );

    flash_seq_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_pg_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (pgf_push),
        .wdata(pgf_wdata),
        .pop  (pg_pop),
        .rdata(fl_wdata),
        .full (pgf_full),
        .empty(pgf_empty)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.init_cnt != '0) s_d.init_cnt = s_q.init_cnt - 1'b1;
        if (addr_we) s_d.addr_reg = addr_wdata;
        if (opstat_clr) begin
            s_d.done = 1'b0;
            s_d.err  = 1'b0;
        end
        case (s_q.st)
            ST_IDLE: begin
                if (ctrl_we && ctrl_wdata[CTL_START] && (s_q.init_cnt == '0)) begin
                    s_d.done  = 1'b0;
                    s_d.err   = 1'b0;
                    s_d.cause = '0;
                    s_d.op    = op_w;
                    s_d.part  = ctrl_wdata[CTL_PART];
                    s_d.info  = ctrl_wdata[CTL_INFO_LSB +: 2];
                    s_d.bank  = ctrl_wdata[CTL_BANK];
                    s_d.cur   = dec_addr;
                    s_d.left  = cnt_w;
                    case (op_w)
                        OP_READ, OP_PROG: begin
                            if (dec_cross) begin
                                s_d.done      = 1'b1;
                                s_d.err       = 1'b1;
                                s_d.cause.win = 1'b1;
                            end else begin
                                s_d.st = ST_XFER;
                            end
                        end
                        OP_ERASE: s_d.st = ST_ERASE;
                        default: begin
                            s_d.done     = 1'b1;
                            s_d.err      = 1'b1;
                            s_d.cause.op = 1'b1;
                        end
                    endcase
                end
            end
            ST_XFER: begin
                if (fire) begin
                    if (fl_err) begin
                        if (s_q.op == OP_READ) s_d.cause.rd = 1'b1;
                        else                   s_d.cause.prog = 1'b1;
                    end
                    if (s_q.left == '0) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.err  = s_d.cause.rd | s_d.cause.prog;
                    end else begin
                        s_d.left = s_q.left - 1'b1;
                        s_d.cur  = s_q.cur + ADDR_W'(4);
                    end
                end
            end
            ST_ERASE: begin
                if (fire) begin
                    s_d.st          = ST_IDLE;
                    s_d.done        = 1'b1;
                    s_d.err         = fl_err;
                    s_d.cause.macro = fl_err;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
            s_q.op       <= OP_READ;
            s_q.init_cnt <= INIT_W'(INIT_CYCLES);
        end else begin
            s_q <= s_d;
        end
    end

    assign op_done   = s_q.done;
    assign op_err    = s_q.err;
    assign err_cause = s_q.cause;
    assign busy      = (s_q.st != ST_IDLE);
    assign init_wip  = (s_q.init_cnt != '0);
    assign fl_op     = s_q.op;
    assign fl_part   = s_q.part;
    assign fl_info   = s_q.info;
    assign fl_bank   = s_q.bank;
    assign fl_addr   = s_q.cur;

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk #(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned PAGE_BYTES = 2048,
    parameter int unsigned BANK_PAGES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic [31:0]       ctrl_wdata,
    input logic              op_done,
    input logic              op_err,
    input logic              busy,
    input logic              init_wip,
    input logic              rdf_full,
    input logic              pgf_empty,
    input logic              fl_req,
    input logic [1:0]        fl_op,
    input logic              fl_bank,
    input logic [ADDR_W-1:0] fl_addr
);
    localparam logic [ADDR_W-1:0] PAGE_LOW = ADDR_W'(PAGE_BYTES - 1);
    localparam logic [ADDR_W-1:0] BANK_LOW = ADDR_W'(PAGE_BYTES * BANK_PAGES - 1);

    assert_word_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (fl_op != 2'd2) |-> (fl_addr[1:0] == 2'b00));

    assert_page_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (fl_op == 2'd2) && !fl_bank |-> ((fl_addr & PAGE_LOW) == '0));

    assert_bank_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (fl_op == 2'd2) && fl_bank |-> ((fl_addr & BANK_LOW) == '0));

    assert_rd_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (fl_op == 2'd0) |-> !rdf_full);

    assert_prog_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && (fl_op == 2'd1) |-> !pgf_empty);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> op_done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !busy);

    assert_init_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_wip |-> (!busy && !fl_req));

    assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(fl_op));

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && ctrl_wdata[0] && (ctrl_wdata[2:1] == 2'd3) && !busy && !init_wip
        |=> op_done && op_err && !busy && !fl_req);

endmodule

bind flash_op_seq flash_op_seq_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .BANK_PAGES(BANK_PAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ctrl_wdata(ctrl_wdata),
    .op_done   (op_done),
    .op_err    (op_err),
    .busy      (busy),
    .init_wip  (init_wip),
    .rdf_full  (rdf_full),
    .pgf_empty (pgf_empty),
    .fl_req    (fl_req),
    .fl_op     (fl_op),
    .fl_bank   (fl_bank),
    .fl_addr   (fl_addr)
);

// File: tb/flash_op_seq_bench.sv
module flash_op_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_we = 1'b0;
    logic [19:0] addr_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        opstat_clr = 1'b0;
    logic        op_done, op_err, busy, init_wip;
    logic [4:0]  err_cause;
    logic        rdf_full, rdf_empty, pgf_full, pgf_empty;
    logic        rdf_pop = 1'b0;
    logic [31:0] rdf_rdata;
    logic        pgf_push = 1'b0;
    logic [31:0] pgf_wdata = '0;
    logic        fl_req, fl_part, fl_bank, fl_ack;
    logic [1:0]  fl_op, fl_info;
    logic [19:0] fl_addr;
    logic [31:0] fl_wdata, fl_rdata;
    logic        fl_err;
    logic        ack_en = 1'b1;
    logic        err_inj = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [19:0] expq[$];
    logic [31:0] rdq[$];
    logic [31:0] pgq[$];
    int exp_op = 0, exp_part = 0, exp_info = 0, exp_bank = 0;

    always #4 clk = ~clk;

    assign fl_ack   = fl_req && ack_en;
    assign fl_rdata = {12'hA5A, fl_addr};
    assign fl_err   = err_inj;

    flash_op_seq u_flash_op_seq (
        .clk(clk), .rst_n(rst_n),
        .addr_we(addr_we), .addr_wdata(addr_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .opstat_clr(opstat_clr),
        .op_done(op_done), .op_err(op_err), .err_cause(err_cause), .busy(busy),
        .rdf_full(rdf_full), .rdf_empty(rdf_empty),
        .pgf_full(pgf_full), .pgf_empty(pgf_empty), .init_wip(init_wip),
        .rdf_pop(rdf_pop), .rdf_rdata(rdf_rdata),
        .pgf_push(pgf_push), .pgf_wdata(pgf_wdata),
        .fl_req(fl_req), .fl_op(fl_op), .fl_part(fl_part), .fl_info(fl_info),
        .fl_bank(fl_bank), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_ack(fl_ack), .fl_rdata(fl_rdata), .fl_err(fl_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: FIFO contents, expected addresses and data, advanced every negedge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic        rd_new;
            logic [31:0] rd_word;
            logic        pg_pop;
            bit          pg_full_now;
            rd_new = 1'b0; rd_word = '0; pg_pop = 1'b0;
            pg_full_now = (pgq.size() == 4);
            chk(rdf_full == (rdq.size() == 4), "R11 read full flag", rdf_full, rdq.size() == 4);
            chk(rdf_empty == (rdq.size() == 0), "R11 read empty flag", rdf_empty, rdq.size() == 0);
            chk(pgf_full == pg_full_now, "R11 program full flag", pgf_full, pg_full_now);
            chk(pgf_empty == (pgq.size() == 0), "R11 program empty flag", pgf_empty, pgq.size() == 0);
            if (fl_req && fl_op == 2'd0 && rdq.size() == 4)
                chk(1'b0, "R6 request while read FIFO full", fl_req, 0);
            if (fl_req && fl_ack) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9 unexpected array request", {12'h0, fl_addr}, 0);
                end else begin
                    logic [19:0] a;
                    a = expq.pop_front();
                    chk(fl_addr == a, "R3 array address", {12'h0, fl_addr}, {12'h0, a});
                    chk(fl_op == 2'(exp_op), "R1 operation", fl_op, exp_op);
                    if (exp_op == 2) begin
                        chk(fl_bank == 1'(exp_bank), "R4 erase kind", fl_bank, exp_bank);
                    end else begin
                        chk(fl_part == 1'(exp_part), "R1 partition", fl_part, exp_part);
                        chk(fl_info == 2'(exp_info), "R1 info type", fl_info, exp_info);
                    end
                    if (exp_op == 0) begin
                        rd_new = 1'b1;
                        rd_word = {12'hA5A, a};
                    end
                    if (exp_op == 1) begin
                        chk(pgq.size() > 0 && fl_wdata == pgq[0], "R7 program data",
                            fl_wdata, (pgq.size() > 0) ? pgq[0] : 32'h0);
                        pg_pop = 1'b1;
                    end
                end
            end
            if (rdf_pop && rdq.size() > 0) begin
                chk(rdf_rdata == rdq[0], "R6 read data order", rdf_rdata, rdq[0]);
                void'(rdq.pop_front());
            end
            if (rd_new) rdq.push_back(rd_word);
            if (pg_pop && pgq.size() > 0) void'(pgq.pop_front());
            if (pgf_push && !pg_full_now) pgq.push_back(pgf_wdata);
        end
    end

    task automatic start_op(input int op, input int part, input int info, input int bank,
                            input int cnt, input logic [19:0] a, input bit enq);
        @(posedge clk); #1;
        addr_we = 1'b1; addr_wdata = a;
        @(posedge clk); #1;
        addr_we = 1'b0;
        ctrl_we = 1'b1;
        ctrl_wdata = (32'(cnt) << 16) | (32'(bank) << 6) | (32'(info) << 4) |
                     (32'(part) << 3) | (32'(op) << 1) | 32'd1;
        if (enq) begin
            exp_op = op; exp_part = part; exp_info = info; exp_bank = bank;
            if (op == 2) begin
                expq.push_back(bank != 0 ? (a & ~20'h07FFF) : (a & ~20'h007FF));
            end else if (op != 3) begin
                for (int i = 0; i <= cnt; i++) expq.push_back((a & ~20'h3) + 20'(4 * i));
            end
        end
        @(posedge clk); #1;
        ctrl_we = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!op_done && n < 2000);
        chk(op_done, req, op_done, 1);
    endtask

    task automatic push_words(input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            pgf_push = 1'b1; pgf_wdata = seed + 32'(i * 32'h111);
        end
        @(posedge clk); #1;
        pgf_push = 1'b0;
    endtask

    task automatic drain(input int cycles);
        @(posedge clk); #1;
        rdf_pop = 1'b1;
        repeat (cycles) @(posedge clk);
        #1 rdf_pop = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int wip_cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk(!op_done && !op_err && !busy && !fl_req, "R12 reset outputs",
            {op_done, op_err, busy, fl_req}, 0);
        chk(rdf_empty && pgf_empty, "R12 FIFOs empty in reset", {rdf_empty, pgf_empty}, 2'b11);

        @(posedge clk); #1;
        rst_n = 1'b1;
        wip_cnt = 0;
        fork
            begin
                for (int i = 0; i < 20; i++) begin
                    @(negedge clk);
                    if (init_wip) wip_cnt++;
                end
            end
            begin
                start_op(0, 0, 0, 0, 1, 20'h00100, 1'b0); // R9: start during init ignored
            end
        join
        chk(wip_cnt == 8, "R11 init cycles", wip_cnt, 8);
        chk(!busy && !op_done, "R9 start during init ignored", {busy, op_done}, 0);

        // R2 R3: read 4 words from an unaligned address, fills the read FIFO
        start_op(0, 0, 0, 0, 3, 20'h00107, 1'b1);
        wait_done("R2 read done");
        chk(!op_err && err_cause == 5'd0, "R8 clean read", {err_cause, op_err}, 0);
        chk(expq.size() == 0, "R2 read word count", expq.size(), 0);
        chk(rdf_full, "R6 read FIFO full after four words", rdf_full, 1);
        drain(6);

        // R5 R6: read across a window with back pressure, info partition
        start_op(0, 1, 2, 0, 6, 20'h003F8, 1'b1);
        repeat (12) @(negedge clk);
        chk(busy && expq.size() == 3, "R6 back pressure holds read", expq.size(), 3);
        @(posedge clk); #1;
        rdf_pop = 1'b1;
        wait_done("R5 read across window completes");
        chk(!op_err, "R5 read not refused", op_err, 0);
        repeat (6) @(posedge clk);
        #1 rdf_pop = 1'b0;

        // R7: program stalls on an empty FIFO
        start_op(1, 0, 0, 0, 2, 20'h02034, 1'b1);
        repeat (6) @(negedge clk);
        chk(busy && expq.size() == 3, "R7 program stalls while empty", expq.size(), 3);
        push_words(3, 32'hC0DE0000);
        wait_done("R7 program done");
        chk(!op_err && expq.size() == 0, "R2 program word count", expq.size(), 0);

        // R5 boundary: last two words of a window are allowed
        push_words(2, 32'h5EED0000);
        start_op(1, 0, 0, 0, 1, 20'h02038, 1'b1);
        wait_done("R5 program up to window end");
        chk(!op_err, "R5 window end accepted", op_err, 0);

        // R5: crossing the window is refused
        start_op(1, 0, 0, 0, 2, 20'h02038, 1'b0);
        @(negedge clk);
        chk(op_done && op_err && err_cause == 5'b01000, "R5 window crossing refused",
            {op_done, op_err, err_cause}, {2'b11, 5'b01000});

        // R8: clear done and error, cause holds
        @(posedge clk); #1 opstat_clr = 1'b1;
        @(posedge clk); #1 opstat_clr = 1'b0;
        @(negedge clk);
        chk(!op_done && !op_err, "R8 clear done and error", {op_done, op_err}, 0);
        chk(err_cause == 5'b01000, "R8 cause held after clear", err_cause, 5'b01000);

        // R4: page erase
        start_op(2, 0, 0, 0, 0, 20'h12345, 1'b1);
        wait_done("R4 page erase done");
        chk(!op_err && err_cause == 5'd0, "R8 cause cleared by start", err_cause, 0);

        // R4 R8: bank erase with array error
        err_inj = 1'b1;
        start_op(2, 0, 0, 1, 0, 20'h12345, 1'b1);
        wait_done("R4 bank erase done");
        chk(op_err && err_cause == 5'b10000, "R8 erase error cause", err_cause, 5'b10000);
        err_inj = 1'b0;

        // R10: invalid operation
        start_op(3, 0, 0, 0, 0, 20'h00000, 1'b1);
        @(negedge clk);
        chk(op_done && op_err && err_cause == 5'b00001, "R10 invalid operation",
            {op_done, op_err, err_cause}, {2'b11, 5'b00001});

        // R9: start while busy ignored
        ack_en = 1'b0;
        start_op(0, 0, 1, 0, 1, 20'h00040, 1'b1);
        start_op(2, 0, 0, 1, 0, 20'h08000, 1'b0);
        @(negedge clk);
        chk(busy && fl_op == 2'd0, "R9 busy start ignored", fl_op, 0);
        @(posedge clk); #1 ack_en = 1'b1;
        wait_done("R9 first operation completes");
        chk(expq.size() == 0 && !op_err, "R9 only first operation ran", expq.size(), 0);
        drain(4);
        repeat (3) @(negedge clk);
        chk(!busy && !op_done == 1'b0, "R9 no second operation", busy, 0);

        // R8: read error
        err_inj = 1'b1;
        start_op(0, 0, 0, 0, 1, 20'h00080, 1'b1);
        wait_done("R8 read with error done");
        chk(op_err && err_cause == 5'b00010, "R8 read error cause", err_cause, 5'b00010);
        err_inj = 1'b0;
        drain(4);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule